// File: doc/BRIEF.md
# I2C Display-Identification Slave

This block is a target on a two-wire I2C bus. It lets a host read and rewrite display-identification tables held in the local RAM of a small controller. It only ever acts as a slave. A 3-bit compatibility code picks the device addresses the block answers to. Each address it accepts selects either a 128-entry first-generation table or a 256-entry second-generation table. The code is captured only while the block is disabled, so a live bus never sees the address set change.

Every byte that moves between the bus and RAM goes through a small direct-memory sequencer. The sequencer holds the memory request and the CPU stall line for exactly two clock cycles per byte. A write transaction first sets the table offset, then stores data with auto-increment. A read transaction streams bytes from the current offset until the master answers with NACK. SCL and SDA are synchronized to the system clock, and SDA is driven open-drain through an output enable.

Top module: `edid_i2c_slave`

## Requirements
- R1: The 7-bit address received after START is compared against the set selected by `cfg_i`. Code 000 or 100 accepts 0x50 (bytes A0h/A1h, small table). Code 001 accepts 0x51 (A2h/A3h, large table). Code 010 or 110 accepts 0x50 (small table) and 0x51 (large table). Code 011 accepts 0x53 (A6h/A7h, large table). An accepted address is acknowledged by pulling SDA low during the ninth SCL clock.
- R2: The reserved codes 101 and 111 accept no address.
- R3: An address that does not match gets NACK (SDA released). The block then acknowledges nothing and touches no memory until the next START.
- R4: `cfg_i` is sampled only while `en_i` is 0; changes made while enabled have no effect. While `en_i` is 0, SDA is never driven.
- R5: In a write transaction, the first data byte sets the table offset. Each following byte is stored at the table base plus the offset, and the offset then increments, wrapping inside the table size. The small table occupies memory words 0..127 and the large table occupies words 256..511. Every data byte is acknowledged.
- R6: In a read transaction, bytes are returned MSB first from the current offset. The offset increments after each byte, wrapping inside the table size. A master ACK fetches the next byte. A master NACK ends the transfer with SDA released.
- R7: Each byte moved between the bus and memory asserts `mem_req_o` and `cpu_stall_o` for exactly two consecutive clock cycles.
- R8: START is SDA falling while SCL is high, and a repeated START restarts address reception from any state. STOP is SDA rising while SCL is high, and it returns the block to idle.
- R9: After reset SDA is released, and the block starts driving SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Interface enable |
| cfg_i | input | 3 | Compatibility code selecting the address set |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line (resolved wired-AND level) |
| sda_oe_o | output | 1 | Pulls SDA low when 1 |
| mem_req_o | output | 1 | Memory access in progress |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 9 | Memory word address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data |
| cpu_stall_o | output | 1 | CPU hold during a byte transfer |

## Verification
The bench builds the block with its defaults: two synchronizer stages, a 256-entry large table and a two-cycle stall. These values keep the whole 512-word memory model and all eight compatibility codes within a short run. For every code, the bench offers each of the three legal addresses plus one address that never matches. Where an address is accepted, it writes at the last offset of the table so that the wrap to entry zero shows up, then reads the data back across that wrap using a repeated START. Stall cycles are counted against twice the number of bytes moved. A final pass changes the code while the block is enabled and addresses the block while it is disabled.

// File: rtl/edid_pkg.sv
package edid_pkg;
  localparam logic [6:0] DEV_V1 = 7'h50;
  localparam logic [6:0] DEV_V2 = 7'h51;
  localparam logic [6:0] DEV_FP = 7'h53;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_OFFS, ST_WDAT, ST_ACKW, ST_ACK, ST_RDAT, ST_MACK
  } state_e;
endpackage

// File: rtl/edid_bus_sync.sv
module edid_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/edid_addr_match.sv
module edid_addr_match
  import edid_pkg::*;
(
  input  logic [2:0] cfg_i,
  input  logic [6:0] dev_i,
  output logic       hit_o,
  output logic       v2_o
);
  always_comb begin
    hit_o = 1'b0;
    v2_o  = 1'b0;
    case (cfg_i)
      3'b000, 3'b100: hit_o = (dev_i == DEV_V1);
      3'b001: begin
        hit_o = (dev_i == DEV_V2);
        v2_o  = 1'b1;
      end
      3'b010, 3'b110: begin
        hit_o = (dev_i == DEV_V1) || (dev_i == DEV_V2);
        v2_o  = (dev_i == DEV_V2);
      end
      3'b011: begin
        hit_o = (dev_i == DEV_FP);
        v2_o  = 1'b1;
      end
      default: ;  // 1x1 reserved
    endcase
  end
endmodule

// File: rtl/edid_dma.sv
module edid_dma #(
  parameter int AW  = 9,
  parameter int DW  = 8,
  parameter int CYC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic [DW-1:0] rdata_o
);
  localparam int CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] CYC_C = CW'(CYC);

  logic [CW-1:0] cnt_q;
  logic          we_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      we_q        <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      rdata_o     <= '0;
    end else if (go_i) begin
      cnt_q       <= CYC_C;
      we_q        <= we_i;
      mem_addr_o  <= addr_i;
      mem_wdata_o <= wdata_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1) && !we_q) rdata_o <= mem_rdata_i;
    end
  end

  assign mem_req_o = (cnt_q != '0);
  assign mem_we_o  = mem_req_o & we_q;
endmodule

// File: rtl/edid_i2c_slave.sv
module edid_i2c_slave
  import edid_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TBL_AW      = 8,
  parameter int STALL_CYC   = 2,
  parameter int MEM_AW      = TBL_AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [2:0]        cfg_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              cpu_stall_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;

  edid_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(bus_start), .stop_o(bus_stop)
  );

  logic [2:0] cfg_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cfg_q <= '0;
    else if (!en_i) cfg_q <= cfg_i;
  end

  state_e            st_q, nxt_q;
  logic [2:0]        bit_q;
  logic [7:0]        sr_q, tx_q;
  logic [TBL_AW-1:0] off_q;
  logic              v2_q;
  logic              go_q, we_q;
  logic [MEM_AW-1:0] dma_addr_q;
  logic [7:0]        dma_wdata_q, dma_rdata;
  logic [7:0]        rx_byte;
  logic              hit, hit_v2;

  assign rx_byte = {sr_q[6:0], sda_s};

  edid_addr_match u_match (.cfg_i(cfg_q), .dev_i(rx_byte[7:1]), .hit_o(hit), .v2_o(hit_v2));

  function automatic logic [MEM_AW-1:0] tbl_addr(input logic v2, input logic [TBL_AW-1:0] off);
    return v2 ? {1'b1, off} : {2'b00, off[TBL_AW-2:0]};
  endfunction

  function automatic logic [TBL_AW-1:0] wrap_inc(input logic v2, input logic [TBL_AW-1:0] off);
    logic [TBL_AW-1:0] n;
    n = off + 1'b1;
    if (!v2) n[TBL_AW-1] = 1'b0;
    return n;
  endfunction

  logic [TBL_AW-1:0] off_nxt;
  assign off_nxt = wrap_inc(v2_q, off_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      nxt_q       <= ST_IDLE;
      bit_q       <= '0;
      sr_q        <= '0;
      tx_q        <= '0;
      off_q       <= '0;
      v2_q        <= 1'b0;
      sda_oe_o    <= 1'b0;
      go_q        <= 1'b0;
      we_q        <= 1'b0;
      dma_addr_q  <= '0;
      dma_wdata_q <= '0;
    end else begin
      go_q <= 1'b0;
      if (!en_i) begin
        st_q     <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else if (bus_start) begin
        st_q     <= ST_ADDR;
        bit_q    <= '0;
        sda_oe_o <= 1'b0;
      end else if (bus_stop) begin
        st_q     <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        case (st_q)
          ST_ADDR, ST_OFFS, ST_WDAT: if (scl_rise) begin
            sr_q  <= rx_byte;
            bit_q <= bit_q + 1'b1;
            if (bit_q == 3'd7) begin
              st_q <= ST_ACKW;
              if (st_q == ST_ADDR) begin
                if (!hit) st_q <= ST_IDLE;
                v2_q <= hit_v2;
                if (hit && rx_byte[0]) begin
                  go_q       <= 1'b1;
                  we_q       <= 1'b0;
                  dma_addr_q <= tbl_addr(hit_v2, off_q);
                  nxt_q      <= ST_RDAT;
                end else begin
                  nxt_q <= ST_OFFS;
                end
              end else if (st_q == ST_OFFS) begin
                off_q <= v2_q ? rx_byte : {1'b0, rx_byte[TBL_AW-2:0]};
                nxt_q <= ST_WDAT;
              end else begin
                go_q        <= 1'b1;
                we_q        <= 1'b1;
                dma_addr_q  <= tbl_addr(v2_q, off_q);
                dma_wdata_q <= rx_byte;
                off_q       <= off_nxt;
                nxt_q       <= ST_WDAT;
              end
            end
          end
          ST_ACKW: if (scl_fall) begin
            sda_oe_o <= 1'b1;
            st_q     <= ST_ACK;
          end
          ST_ACK: if (scl_fall) begin
            bit_q <= '0;
            if (nxt_q == ST_RDAT) begin
              tx_q     <= dma_rdata;
              sda_oe_o <= ~dma_rdata[7];
            end else begin
              sda_oe_o <= 1'b0;
            end
            st_q <= nxt_q;
          end
          ST_RDAT: if (scl_fall) begin
            if (bit_q == 3'd7) begin
              sda_oe_o <= 1'b0;
              st_q     <= ST_MACK;
            end else begin
              tx_q     <= {tx_q[6:0], 1'b0};
              sda_oe_o <= ~tx_q[6];
              bit_q    <= bit_q + 1'b1;
            end
          end
          ST_MACK: if (scl_rise) begin
            off_q <= off_nxt;
            if (!sda_s) begin
              go_q       <= 1'b1;
              we_q       <= 1'b0;
              dma_addr_q <= tbl_addr(v2_q, off_nxt);
              nxt_q      <= ST_RDAT;
              st_q       <= ST_ACK;
            end else begin
              st_q <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  edid_dma #(.AW(MEM_AW), .DW(8), .CYC(STALL_CYC)) u_dma (
    .clk_i, .rst_ni, .go_i(go_q), .we_i(we_q), .addr_i(dma_addr_q), .wdata_i(dma_wdata_q),
    .mem_rdata_i, .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .rdata_o(dma_rdata)
  );

  assign cpu_stall_o = mem_req_o;
endmodule

// File: rtl/edid_i2c_slave_chk.sv
module edid_i2c_slave_chk #(
  parameter int MEM_AW = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              scl_s,
  input logic [2:0]        cfg_q,
  input logic              sda_oe_o,
  input logic              mem_req_o,
  input logic [MEM_AW-1:0] mem_addr_o,
  input logic              cpu_stall_o
);
  a_r4_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && $past(en_i) |-> $stable(cfg_q));

  a_r4_quiet_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !sda_oe_o);

  a_r7_stall_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_stall_o) |=> cpu_stall_o);

  a_r7_stall_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_stall_o && $past(cpu_stall_o) |=> !cpu_stall_o);

  a_r9_drive_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_s);

  a_r5_small_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_addr_o[MEM_AW-1] |-> !mem_addr_o[MEM_AW-2]);
endmodule

bind edid_i2c_slave edid_i2c_slave_chk #(.MEM_AW(MEM_AW)) u_chk (
  .clk_i, .rst_ni, .en_i, .scl_s, .cfg_q, .sda_oe_o, .mem_req_o, .mem_addr_o, .cpu_stall_o
);

// File: tb/tb_edid_i2c_slave.sv
module tb_edid_i2c_slave;
  localparam int Q = 5;
  localparam int H = 10;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [2:0] cfg = '0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, mem_req, mem_we, cpu_stall;
  logic [8:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic sda_line;
  logic [7:0] mem [512];
  int checks = 0, errs = 0, stall_cnt = 0;

  always #10 clk = ~clk;

  assign sda_line  = sda_m & ~sda_oe;
  assign mem_rdata = mem[mem_addr];

  edid_i2c_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .cfg_i(cfg), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .cpu_stall_o(cpu_stall)
  );

  always @(posedge clk) begin
    if (mem_req && mem_we) mem[mem_addr] <= mem_wdata;
    if (cpu_stall) stall_cnt <= stall_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; w(Q); scl = 1'b1; w(H); sda_m = 1'b0; w(H); scl = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; w(Q); scl = 1'b1; w(H); sda_m = 1'b1; w(H);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; w(Q); scl = 1'b1; w(H); scl = 1'b0; w(Q);
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; w(Q); scl = 1'b1; w(H/2); b = sda_line; w(H/2); scl = 1'b0; w(Q);
  endtask

  task automatic wbyte(input logic [7:0] d, output logic nack);
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(nack);
  endtask

  task automatic rbyte(input logic last, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) bit_in(d[i]);
    bit_out(last);
  endtask

  function automatic bit exp_hit(input int c, input logic [6:0] dv, output bit v2);
    v2 = (dv != 7'h50);
    case (c)
      0, 4:    return dv == 7'h50;
      1:       return dv == 7'h51;
      2, 6:    return dv == 7'h50 || dv == 7'h51;
      3:       return dv == 7'h53;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    logic nk;
    logic [7:0] rd;
    logic [6:0] devs [4];
    devs[0] = 7'h50; devs[1] = 7'h51; devs[2] = 7'h53; devs[3] = 7'h52;
    for (int i = 0; i < 512; i++) mem[i] = 8'((i * 7 + 3) & 255);
    w(5);
    // R9: released after reset
    chk(sda_oe == 1'b0, "R9 reset sda", int'(sda_oe), 0);
    chk(cpu_stall == 1'b0 && mem_req == 1'b0, "R7 reset stall", int'(cpu_stall), 0);
    rst_n = 1'b1; w(3);

    for (int c = 0; c < 8; c++) begin
      en = 1'b0; cfg = 3'(c); w(3); en = 1'b1; w(3);
      for (int ai = 0; ai < 4; ai++) begin
        bit v2, hit;
        int base, s0;
        logic [7:0] off, d0, d1;
        hit  = exp_hit(c, devs[ai], v2);
        base = v2 ? 256 : 0;
        off  = v2 ? 8'hFF : 8'h7F;
        d0   = 8'(8'h30 + c * 4 + ai);
        d1   = ~d0;
        s0   = stall_cnt;
        bus_start();
        wbyte({devs[ai], 1'b0}, nk);
        // R1 match / R2 reserved codes
        chk(nk == !hit, (c == 5 || c == 7) ? "R2 reserved addr" : "R1 addr ack", int'(nk), int'(!hit));
        if (!hit) begin
          wbyte(8'h00, nk);
          chk(nk == 1'b1, "R3 ignored after mismatch", int'(nk), 1);
          wbyte(8'h5A, nk);
          bus_stop();
          chk(stall_cnt == s0, "R3 no mem access", stall_cnt - s0, 0);
          continue;
        end
        wbyte(off, nk);
        wbyte(d0, nk);
        chk(nk == 1'b0, "R5 data ack", int'(nk), 0);
        wbyte(d1, nk);
        bus_stop();
        chk(mem[base + int'(off)] == d0, "R5 write at offset", int'(mem[base + int'(off)]), int'(d0));
        chk(mem[base] == d1, "R5 write wraps", int'(mem[base]), int'(d1));
        chk(stall_cnt - s0 == 4, "R7 stall per written byte", stall_cnt - s0, 4);
        s0 = stall_cnt;
        // R8 repeated START between offset write and read
        bus_start();
        wbyte({devs[ai], 1'b0}, nk);
        wbyte(off, nk);
        bus_start();
        wbyte({devs[ai], 1'b1}, nk);
        chk(nk == 1'b0, "R8 repeated start addr ack", int'(nk), 0);
        rbyte(1'b0, rd);
        chk(rd == d0, "R6 read first", int'(rd), int'(d0));
        rbyte(1'b0, rd);
        chk(rd == d1, "R6 read wraps", int'(rd), int'(d1));
        rbyte(1'b1, rd);
        chk(rd == mem[base + 1], "R6 read third", int'(rd), int'(mem[base + 1]));
        chk(sda_oe == 1'b0, "R6 released after nack", int'(sda_oe), 0);
        bus_stop();
        chk(stall_cnt - s0 == 6, "R7 stall per read byte", stall_cnt - s0, 6);
      end
    end

    // R4: code change while enabled is ignored
    en = 1'b0; cfg = 3'b001; w(3); en = 1'b1; w(3);
    cfg = 3'b000; w(3);
    bus_start(); wbyte(8'hA0, nk); bus_stop();
    chk(nk == 1'b1, "R4 cfg locked A0", int'(nk), 1);
    bus_start(); wbyte(8'hA2, nk); bus_stop();
    chk(nk == 1'b0, "R4 cfg locked A2", int'(nk), 0);
    // R4: disabled block stays silent
    en = 1'b0; w(3);
    bus_start(); wbyte(8'hA2, nk); bus_stop();
    chk(nk == 1'b1, "R4 disabled no ack", int'(nk), 1);
    // R8: STOP returns to idle; data after STOP without START is ignored
    en = 1'b1; w(3);
    bus_start(); wbyte(8'hA2, nk); bus_stop();
    wbyte(8'hA2, nk);
    chk(nk == 1'b1, "R8 idle after stop", int'(nk), 1);
    bus_stop();

    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule